// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is a character-wide serial peripheral unit. On one side it has a small register port for a host processor. On the other side it has a four-wire serial port: clock, master-out data, master-in data and an active-low select input. The unit runs either as the clock-generating master or as a slave that follows an external clock. The host picks the role, the clock idle level and the sampling phase in a mode register. In master mode it also sets a divide ratio that gives the serial clock rate. Characters are eight bits by default and are shifted most significant bit first.

The host writes characters into a one-deep transmit holding register. As master, the unit moves each held character into its shifter and toggles the serial clock only while that character is in flight. A frame is a run of characters that ends on the character taken after the host sets a last-character command. When that character completes, a frame-done event is raised. Received characters land in a receive register and raise a not-empty event. All events are sticky and are cleared by writing ones.

The select pin is never driven by the unit. Slaves are selected by a general-purpose output elsewhere on the chip. If the select input goes low while the unit is an enabled master, another master is on the bus. The unit flags a fault, drops its enable bit and releases its outputs.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, the mode register (address 0) and the event register (address 4) read zero, and none of the three output enables is asserted.
- R2: Mode register bits are: bit 0 enable, bit 1 master, bit 2 clock idles high, bit 3 phase. With phase 0, data is sampled on the leading clock edge; with phase 1, it is sampled on the trailing edge. In all four idle/phase combinations, a master whose data-in is wired to its own data-out reads back the character it sent, MSB first, from address 3.
- R3: In master mode, each serial clock half period lasts 2*(D+1) system clocks, where D is the divide ratio held at address 1.
- R4: In master mode, the serial clock sits at the configured idle level whenever no character is in flight.
- R5: As an enabled master, the unit drives the clock and data-out enables and samples the data-in pin. As a slave, it drives neither.
- R6: As a slave, the unit shifts on the external clock only while the select input is low. It drives data-out of the slave (miso) only then, sending the held character MSB first and capturing the incoming one. Clock edges while the select input is high do nothing.
- R7: If the select input reads low while the unit is an enabled master, event bit 3 (multimaster fault) is set, the enable bit clears, and the clock and data outputs are released.
- R8: When a character completes and event bit 0 (not-empty) is clear, the character is written to address 3 and bit 0 is set.
- R9: Moving the held character (written at address 2) into the shifter sets event bit 1. Writing 1 to bit 0 of address 5 marks the next taken character as last. Event bit 2 (frame done) is set only when such a marked character completes.
- R10: Event bits stay set until a write to address 4 with a 1 in that bit position. Zero bits in the write leave the other events unchanged.
- R11: A character that completes while event bit 0 is still set sets event bit 4 (overrun) and is discarded. The receive register keeps the older character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CHAR_W | Register write data |
| bus_rdata | output | CHAR_W | Register read data for bus_addr (combinational) |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock generated in master mode |
| sclk_oe | output | 1 | Drive enable for sclk_o |
| mosi_i | input | 1 | Master-to-slave data when acting as slave |
| mosi_o | output | 1 | Master-to-slave data when acting as master |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Slave-to-master data when acting as master |
| miso_o | output | 1 | Slave-to-master data when acting as slave |
| miso_oe | output | 1 | Drive enable for miso_o |
| sel_n_i | input | 1 | Active-low select, an input in every mode |

## Verification
The bench builds the block with eight-bit characters, a four-bit divide ratio and two synchronizer stages. The narrow divider keeps each master character short, so one vector table can sweep all four clock modes over several ratios and measure every half period exactly. Eight-bit characters allow distinct patterns such as 0x01 and 0xFE, which show the bit order. With two synchronizer stages, an external slave clock of twenty system cycles per bit stays well inside the slave latency, so the bench can compare both directions bit by bit.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

   // register addresses
   localparam logic [2:0] ADDR_MODE = 3'd0;
   localparam logic [2:0] ADDR_DIV  = 3'd1;
   localparam logic [2:0] ADDR_TXD  = 3'd2;
   localparam logic [2:0] ADDR_RXD  = 3'd3;
   localparam logic [2:0] ADDR_EVT  = 3'd4;
   localparam logic [2:0] ADDR_CMD  = 3'd5;

   // event bit positions
   localparam int EV_NE  = 0;
   localparam int EV_TE  = 1;
   localparam int EV_FD  = 2;
   localparam int EV_MME = 3;
   localparam int EV_OVR = 4;
   localparam int EV_W   = 5;

   localparam int MODE_W = 4;

   typedef struct packed {
      logic cpha;
      logic cpol;
      logic master;
      logic en;
   } mode_t;

endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST_VAL;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/spi_ctrl_baud.sv
module spi_ctrl_baud #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic             pre;
   logic [DIV_W-1:0] cnt;

   // half-rate prescale, then a (div+1) counter on the prescaled pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         pre <= 1'b0;
         cnt <= '0;
      end else begin
         pre <= ~pre;
         if (pre) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
      end
   end

   assign tick = run & pre & (cnt == div);

endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         cpha,
   input  logic         lead,
   input  logic         trail,
   input  logic         din,
   output logic         dout,
   output logic         done,
   output logic [W-1:0] rx_word
);

   localparam int            EC_W    = $clog2(2 * W);
   localparam logic [EC_W-1:0] EC_LAST = EC_W'(2 * W - 1);

   logic [EC_W-1:0] ecnt;
   logic [W-1:0]    tx_sh;
   logic [W-1:0]    rx_sh;
   logic            advance, sample, last;

   assign advance = cpha ? (lead && ecnt != '0) : trail;
   assign sample  = cpha ? trail : lead;
   assign last    = trail && (ecnt == EC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
         done  <= 1'b0;
      end else if (clr) begin
         ecnt <= '0;
         done <= 1'b0;
      end else if (load) begin
         tx_sh <= load_data;
         ecnt  <= '0;
         done  <= 1'b0;
      end else begin
         if (lead || trail) ecnt <= last ? '0 : ecnt + 1'b1;
         if (advance)       tx_sh <= {tx_sh[W-2:0], 1'b0};
         if (sample)        rx_sh <= {rx_sh[W-2:0], din};
         done <= last;
      end
   end

   assign dout    = tx_sh[W-1];
   assign rx_word = rx_sh;

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
   import spi_ctrl_pkg::*;
#(
   parameter int CHAR_W      = 8,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [CHAR_W-1:0] bus_wdata,
   output logic [CHAR_W-1:0] bus_rdata,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              sel_n_i
);

   if (CHAR_W < EV_W)     begin : g_bad_char   $error("CHAR_W too narrow for event register"); end
   if (CHAR_W < DIV_W)    begin : g_bad_div    $error("DIV_W exceeds register width"); end
   if (DIV_W < 1)         begin : g_bad_divw   $error("DIV_W must be at least 1"); end
   if (SYNC_STAGES < 1)   begin : g_bad_sync   $error("SYNC_STAGES must be at least 1"); end

   mode_t             mode;
   logic [DIV_W-1:0]  div;
   logic [CHAR_W-1:0] tx_hold, rxd, rx_word, load_data;
   logic [EV_W-1:0]   evt, evt_set, evt_clr;
   logic              tx_full, last_pend, cur_last, busy, lvl;
   logic              sclk_s, mosi_s, sel_s, sclk_prev, sel_prev;
   logic              is_master, is_slave, fault, tick;
   logic              m_lead, m_trail, s_act, s_lead, s_trail, s_fall;
   logic              lead, trail, din, dout, done;
   logic              m_load, s_load, load, take, clr;
   logic              cfg_cpol;

   // pin synchronizers: select resets inactive (high)
   spi_ctrl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n_i, mosi_i, sclk_i}),
      .q     ({sel_s, mosi_s, sclk_s})
   );

   assign is_master = mode.en & mode.master;
   assign is_slave  = mode.en & ~mode.master;
   assign fault     = is_master & ~sel_s;
   assign cfg_cpol  = mode.cpol;

   spi_ctrl_baud #(.DIV_W(DIV_W)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy & ~done),
      .div   (div),
      .tick  (tick)
   );

   assign m_lead  = tick & ~lvl;
   assign m_trail = tick & lvl;

   assign s_act   = is_slave & ~sel_s;
   assign s_lead  = s_act & (sclk_s ^ mode.cpol) & ~(sclk_prev ^ mode.cpol);
   assign s_trail = s_act & ~(sclk_s ^ mode.cpol) & (sclk_prev ^ mode.cpol);
   assign s_fall  = sel_prev & ~sel_s;

   assign lead  = is_master ? m_lead  : s_lead;
   assign trail = is_master ? m_trail : s_trail;
   assign din   = is_master ? miso_i  : mosi_s;

   assign m_load    = is_master & ~fault & tx_full & (~busy | done);
   assign s_load    = s_act & (s_fall | done);
   assign load      = m_load | s_load;
   assign take      = load & tx_full;
   assign load_data = tx_full ? tx_hold : '0;
   assign clr       = ~mode.en | fault | (is_slave & sel_s);

   spi_ctrl_shift #(.W(CHAR_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .load      (load),
      .load_data (load_data),
      .cpha      (mode.cpha),
      .lead      (lead),
      .trail     (trail),
      .din       (din),
      .dout      (dout),
      .done      (done),
      .rx_word   (rx_word)
   );

   // pin edge history
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         sel_prev  <= 1'b1;
      end else begin
         sclk_prev <= sclk_s;
         sel_prev  <= sel_s;
      end
   end

   // master character sequencing and clock level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         lvl  <= 1'b0;
      end else begin
         if (!is_master || fault) busy <= 1'b0;
         else if (m_load)         busy <= 1'b1;
         else if (done)           busy <= 1'b0;

         if (!busy)     lvl <= 1'b0;
         else if (tick) lvl <= ~lvl;
      end
   end

   // event set/clear
   always_comb begin
      evt_set          = '0;
      evt_set[EV_NE]   = done & ~evt[EV_NE];
      evt_set[EV_OVR]  = done & evt[EV_NE];
      evt_set[EV_TE]   = take;
      evt_set[EV_FD]   = done & cur_last;
      evt_set[EV_MME]  = fault;
      evt_clr          = (bus_we && bus_addr == ADDR_EVT) ? bus_wdata[EV_W-1:0] : '0;
   end

   // configuration, holding and receive registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= '0;
         div       <= '0;
         tx_hold   <= '0;
         tx_full   <= 1'b0;
         rxd       <= '0;
         evt       <= '0;
         last_pend <= 1'b0;
         cur_last  <= 1'b0;
      end else begin
         evt <= (evt & ~evt_clr) | evt_set;

         if (done && !evt[EV_NE]) rxd <= rx_word;

         if (load) cur_last <= tx_full & last_pend;
         if (take) begin
            tx_full   <= 1'b0;
            last_pend <= 1'b0;
         end

         if (bus_we) begin
            case (bus_addr)
               ADDR_MODE: mode <= mode_t'(bus_wdata[MODE_W-1:0]);
               ADDR_DIV:  div  <= bus_wdata[DIV_W-1:0];
               ADDR_TXD: begin
                  tx_hold <= bus_wdata;
                  tx_full <= 1'b1;
               end
               ADDR_CMD:  if (bus_wdata[0]) last_pend <= 1'b1;
               default: ;
            endcase
         end

         if (fault) mode.en <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_MODE: bus_rdata[MODE_W-1:0] = mode;
         ADDR_DIV:  bus_rdata[DIV_W-1:0]  = div;
         ADDR_RXD:  bus_rdata             = rxd;
         ADDR_EVT:  bus_rdata[EV_W-1:0]   = evt;
         default: ;
      endcase
   end

   assign sclk_o  = mode.cpol ^ lvl;
   assign sclk_oe = is_master;
   assign mosi_o  = dout;
   assign mosi_oe = is_master;
   assign miso_o  = dout;
   assign miso_oe = s_act;

endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
   import spi_ctrl_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              is_master,
   input logic              busy,
   input logic              cfg_cpol,
   input logic              sclk_o,
   input logic              sclk_oe,
   input logic              mosi_oe,
   input logic [EV_W-1:0]   evt,
   input logic [CHAR_W-1:0] rxd,
   input logic              bus_we,
   input logic [2:0]        bus_addr,
   input logic              wd_ne
);

   logic ne_clr;
   assign ne_clr = bus_we && (bus_addr == ADDR_EVT) && wd_ne;

   // R4: idle master clock rests at the configured level
   p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !busy) |-> (sclk_o == cfg_cpol));

   // R7: a raised multimaster fault comes with released outputs
   p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[EV_MME]) |-> (!sclk_oe && !mosi_oe));

   // R10: not-empty only falls after a write-one clear
   p_ne_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt[EV_NE]) && !$past(ne_clr)) |-> evt[EV_NE]);

   // R11: an overrun leaves the held character alone
   p_ovr_keeps_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[EV_OVR]) |-> $stable(rxd));

endmodule

bind spi_ctrl spi_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .is_master (is_master),
   .busy      (busy),
   .cfg_cpol  (cfg_cpol),
   .sclk_o    (sclk_o),
   .sclk_oe   (sclk_oe),
   .mosi_oe   (mosi_oe),
   .evt       (evt),
   .rxd       (rxd),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .wd_ne     (bus_wdata[0])
);

// File: tb/spi_ctrl_bench.sv
module spi_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CHAR_W     = 8;
   localparam int DIV_W      = 4;
   localparam int H          = 10;

   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_DIV  = 3'd1;
   localparam logic [2:0] A_TXD  = 3'd2;
   localparam logic [2:0] A_RXD  = 3'd3;
   localparam logic [2:0] A_EVT  = 3'd4;
   localparam logic [2:0] A_CMD  = 3'd5;

   // {cpol, cpha, 2'b00, div, character}
   localparam logic [15:0] VEC [6] = '{
      {1'b0, 1'b0, 2'b00, 4'd0, 8'hA5},
      {1'b0, 1'b1, 2'b00, 4'd1, 8'h3C},
      {1'b1, 1'b0, 2'b00, 4'd2, 8'h81},
      {1'b1, 1'b1, 2'b00, 4'd3, 8'h7E},
      {1'b0, 1'b1, 2'b00, 4'd0, 8'h01},
      {1'b1, 1'b0, 2'b00, 4'd5, 8'hFE}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [CHAR_W-1:0] bus_wdata = '0;
   logic [CHAR_W-1:0] bus_rdata;
   logic sclk_i = 1'b0, mosi_i = 1'b0, sel_n_i = 1'b1;
   logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign miso_i = mosi_o;   // master loopback wiring

   spi_ctrl #(.CHAR_W(CHAR_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) u_spi_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .sel_n_i(sel_n_i)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_evt(input int b, output bit ok);
      logic [7:0] v;
      ok = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         rd(A_EVT, v);
         if (v[b]) begin ok = 1'b1; break; end
      end
   endtask

   // external master driving the slave
   task automatic ext_xfer(input logic cpol, input logic cpha,
                           input logic [7:0] tx, output logic [7:0] got);
      @(negedge clk); sel_n_i = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         if (!cpha) begin
            mosi_i = tx[i];
            repeat (H) @(negedge clk);
            got[i] = miso_o;
            sclk_i = ~cpol;
            repeat (H) @(negedge clk);
            sclk_i = cpol;
         end else begin
            sclk_i = ~cpol;
            mosi_i = tx[i];
            repeat (H) @(negedge clk);
            got[i] = miso_o;
            sclk_i = cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      sel_n_i = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v, got;
      bit ok;
      int cnt, bad;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(A_MODE, v); chk("R1 mode", v, 8'h00);
      rd(A_EVT, v);  chk("R1 events", v, 8'h00);
      chk("R1 enables", {sclk_oe, mosi_oe, miso_oe}, 3'b000);

      // R2/R3/R4/R5/R8/R9: master loopback table
      foreach (VEC[n]) begin
         logic cpol, cpha;
         logic [3:0] dv;
         logic [7:0] tx;
         {cpol, cpha} = VEC[n][15:14];
         dv = VEC[n][11:8];
         tx = VEC[n][7:0];
         wr(A_EVT, 8'h1F);
         wr(A_DIV, {4'h0, dv});
         wr(A_MODE, {4'h0, cpha, cpol, 1'b1, 1'b1});
         chk("R5 master enables", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
         wr(A_CMD, 8'h01);
         wr(A_TXD, tx);
         for (int k = 0; k < 200; k++) begin
            if (sclk_o != cpol) break;
            @(negedge clk);
         end
         cnt = 0;
         while (sclk_o != cpol && cnt < 300) begin
            cnt++;
            @(negedge clk);
         end
         chk("R3 half period", cnt, 2 * (dv + 1));
         wait_evt(2, ok);
         chk("R9 frame done seen", ok, 1);
         rd(A_RXD, v);  chk("R2 loopback data", v, tx);
         rd(A_EVT, v);  chk("R8 events after last char", v, 8'h07);
         bad = 0;
         for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (sclk_o !== cpol) bad++;
         end
         chk("R4 idle clock", bad, 0);
      end

      // R9/R11: two-character frame without reading the first
      wr(A_EVT, 8'h1F);
      wr(A_DIV, 8'h01);
      wr(A_MODE, 8'h03);
      wr(A_TXD, 8'h3C);
      wait_evt(0, ok);
      chk("R8 first char ready", ok, 1);
      repeat (4) @(negedge clk);
      rd(A_EVT, v); chk("R9 no frame done on unmarked char", v, 8'h03);
      wr(A_CMD, 8'h01);
      wr(A_TXD, 8'hC3);
      wait_evt(2, ok);
      chk("R9 frame done on marked char", ok, 1);
      rd(A_EVT, v); chk("R11 overrun flagged", v, 8'h17);
      rd(A_RXD, v); chk("R11 older char kept", v, 8'h3C);

      // R10: write-one clear of one bit only
      wr(A_EVT, 8'h10);
      rd(A_EVT, v); chk("R10 selective clear", v, 8'h07);
      wr(A_EVT, 8'h00);
      rd(A_EVT, v); chk("R10 zero write no effect", v, 8'h07);

      // R7: select asserted while master
      wr(A_EVT, 8'h1F);
      @(negedge clk); sel_n_i = 1'b0;
      repeat (6) @(negedge clk);
      rd(A_EVT, v);  chk("R7 fault event", v, 8'h08);
      rd(A_MODE, v); chk("R7 enable cleared", v, 8'h02);
      chk("R7 outputs released", {sclk_oe, mosi_oe}, 2'b00);
      @(negedge clk); sel_n_i = 1'b1;
      repeat (4) @(negedge clk);

      // R6: slave mode 0
      sclk_i = 1'b0;
      wr(A_EVT, 8'h1F);
      wr(A_MODE, 8'h01);
      chk("R5 slave drives no clock", {sclk_oe, mosi_oe}, 2'b00);
      wr(A_TXD, 8'hA5);
      ext_xfer(1'b0, 1'b0, 8'h5A, got);
      chk("R6 slave sent", got, 8'hA5);
      rd(A_RXD, v); chk("R6 slave received", v, 8'h5A);
      rd(A_EVT, v); chk("R8 slave not-empty", v[0], 1'b1);

      // R6: slave mode 3
      @(negedge clk); sclk_i = 1'b1;
      wr(A_EVT, 8'h1F);
      wr(A_MODE, 8'h0D);
      wr(A_TXD, 8'h96);
      ext_xfer(1'b1, 1'b1, 8'hC1, got);
      chk("R6 slave mode3 sent", got, 8'h96);
      rd(A_RXD, v); chk("R6 slave mode3 received", v, 8'hC1);

      // R6: clock ignored while deselected
      wr(A_EVT, 8'h1F);
      bad = 0;
      for (int e = 0; e < 16; e++) begin
         sclk_i = ~sclk_i;
         repeat (H) @(negedge clk);
         if (miso_oe !== 1'b0) bad++;
      end
      sclk_i = 1'b1;
      repeat (H) @(negedge clk);
      chk("R6 miso quiet while deselected", bad, 0);
      rd(A_EVT, v); chk("R6 no capture while deselected", v, 8'h00);
      rd(A_RXD, v); chk("R6 receive untouched", v, 8'hC1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule